// File: doc/BRIEF.md
# Serial Converter Conversion Sequencer

This block is the digital control core on the device side of an 8-channel, 12-bit successive-approximation converter. The host talks to it over a four-wire serial link: active-low select, serial clock, data in and data out. The block hunts for a start bit after select goes low and collects an 8-bit command. From the command fields it sets up the analog front end: it steers the input multiplexer and opens and closes the sampling switch at fixed command-bit positions. It then runs a 12-step binary search against a single comparator bit and shifts the result back to the host, most significant bit first. A strobe pulse marks the start of each result.

All serial-link inputs are treated as synchronous levels and sampled on the core clock. Edges of the serial clock are found by comparing each sample with the one before. The analog comparator sits outside the block. It sees the trial code on `dac_code` and answers on `cmp_in`.

Top module: `adc_serial_seq`

## Requirements
- R1: A command bit is taken from `din` only on a rising `sclk` edge while `cs_n` is low. Edges on `sclk` while `cs_n` is high change no state.
- R2: After `cs_n` falls, zeros are skipped and the first 1 becomes command bit 7 (start). The following bits fill positions 6 down to 0 as follows. Bits 6..4 are the channel number. Bit 3 is 1 for unipolar. Bit 2 is 1 for single-ended and 0 for differential. Bits 1..0 are the mode, where 2'b11 is external-clock conversion.
- R3: `th_track` goes high on the falling `sclk` edge after the 5th command bit and low on the falling edge after the 8th.
- R4: On the falling edge after the 6th command bit, the routing outputs are loaded. In single-ended mode `mux_pos` = channel and `neg_com` = 1. In differential mode `neg_com` = 0 and `mux_pos` = channel, while `mux_neg` is the other member of its pair {0,1}, {2,3}, {4,5} or {6,7}. `unipolar` copies bit 3.
- R5: In mode 2'b11, `sstrb` is high for exactly one `sclk` period, from the falling edge after the 8th command bit to the next falling edge.
- R6: The trial code starts at 0x800 when the strobe rises. On each of the next 12 rising `sclk` edges, one bit from MSB to LSB is decided: it is kept if `cmp_in` = 1 and cleared if 0, and the next lower bit is then set for trial.
- R7: `dout` changes only on falling `sclk` edges. The result appears MSB first, starting on the falling edge that ends the strobe. After the LSB period `dout` returns to 0.
- R8: A new command may start on the 16th `sclk` cycle counted from the previous start bit. Conversions then repeat every 15 `sclk` cycles, each with a correct result.
- R9: While `cs_n` is high, `dout_oe`, `sstrb_oe`, `dout`, `sstrb` and `th_track` are 0. Raising `cs_n` mid-frame aborts the command and any conversion, and the start-bit hunt restarts after `cs_n` falls again. After reset all outputs are 0 except `neg_com` = 1.
- R10: A command whose mode is not 2'b11 still tracks and routes but starts no conversion: `sstrb` and `dout` stay 0.
- R11: The all-ones command 0xFF gives a single-ended, unipolar, external-clock conversion on channel 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select of the serial link |
| sclk | input | 1 | Serial clock level, sampled on `clk` |
| din | input | 1 | Serial command data |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for `dout` |
| sstrb | output | 1 | Conversion strobe |
| sstrb_oe | output | 1 | Drive enable for `sstrb` |
| th_track | output | 1 | Sampling switch closed (tracking) when 1 |
| mux_pos | output | 3 | Positive input channel |
| mux_neg | output | 3 | Negative input channel in differential mode |
| neg_com | output | 1 | Negative input tied to common reference |
| unipolar | output | 1 | Unipolar coding selected |
| dac_code | output | 12 | Current trial or final code |

## Verification
Some rules hold on every cycle and are checked by assertions: the output enables and levels are silent while select is high; the strobe, data output and tracking switch move only on falling serial-clock edges; a strobe spans no more than one rising edge; the search always starts at mid-scale; and a differential route always names the two members of one pair. Only the bench scenarios can show the rest: where tracking opens and closes relative to the command bits, that the shifted result equals the input value, that leading zeros and clocks during deselect are ignored, the 15-cycle back-to-back cadence, abort and restart, and the suppression of conversion in non-external modes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RES_W     = 12;
    localparam int CH_W      = 3;
    localparam int MODE_W    = 2;
    localparam int CTRL_W    = 1 + CH_W + 1 + 1 + MODE_W;
    localparam int TRK_BIT   = 5;
    localparam int ROUTE_BIT = 6;

    localparam logic [MODE_W-1:0] MODE_EXT_CLK = '1;

    typedef struct packed {
        logic              start;
        logic [CH_W-1:0]   chan;
        logic              unipolar;
        logic              single;
        logic [MODE_W-1:0] mode;
    } cmd_t;

    typedef struct packed {
        logic [CH_W-1:0] pos;
        logic [CH_W-1:0] neg;
        logic            neg_com;
    } route_t;

    typedef enum logic {
        RX_HUNT,
        RX_SHIFT
    } rx_state_e;

    function automatic route_t decode_route(input logic [CH_W-1:0] chan,
                                            input logic single);
        route_t r;
        r.pos = chan;
        if (single) begin
            r.neg     = '0;
            r.neg_com = 1'b1;
        end else begin
            r.neg     = {chan[CH_W-1:1], ~chan[0]};
            r.neg_com = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/adc_seq_edge.sv
module adc_seq_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    output logic active,
    output logic sclk_rise,
    output logic sclk_fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk;
        end
    end

    assign active    = ~cs_n;
    assign sclk_rise = active & sclk & ~sclk_q;
    assign sclk_fall = active & ~sclk & sclk_q;
endmodule

// File: rtl/adc_seq_rx.sv
module adc_seq_rx
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic sclk_rise,
    input  logic sclk_fall,
    input  logic din,
    output logic ev_track,
    output logic ev_route,
    output logic ev_hold,
    output cmd_t cmd
);
    localparam int CNT_W = $clog2(CTRL_W + 1);

    rx_state_e        state;
    logic [CNT_W-1:0] nbits;
    cmd_t             frame;
    logic             pend_trk;
    logic             pend_route;
    logic             pend_hold;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            state      <= RX_HUNT;
            nbits      <= '0;
            frame      <= '0;
            pend_trk   <= 1'b0;
            pend_route <= 1'b0;
            pend_hold  <= 1'b0;
        end else begin
            if (sclk_fall) begin
                pend_trk   <= 1'b0;
                pend_route <= 1'b0;
                pend_hold  <= 1'b0;
            end
            if (sclk_rise) begin
                if (state == RX_HUNT) begin
                    if (din) begin
                        frame       <= '0;
                        frame.start <= 1'b1;
                        nbits       <= CNT_W'(1);
                        state       <= RX_SHIFT;
                    end
                end else begin
                    for (int i = 0; i < CTRL_W; i++) begin
                        if (i == CTRL_W - 1 - int'(nbits)) begin
                            frame[i] <= din;
                        end
                    end
                    nbits <= nbits + CNT_W'(1);
                    if (nbits == CNT_W'(TRK_BIT - 1)) begin
                        pend_trk <= 1'b1;
                    end
                    if (nbits == CNT_W'(ROUTE_BIT - 1)) begin
                        pend_route <= 1'b1;
                    end
                    if (nbits == CNT_W'(CTRL_W - 1)) begin
                        pend_hold <= 1'b1;
                        state     <= RX_HUNT;
                    end
                end
            end
        end
    end

    assign ev_track = sclk_fall & pend_trk;
    assign ev_route = sclk_fall & pend_route;
    assign ev_hold  = sclk_fall & pend_hold & frame.start;
    assign cmd      = frame;
endmodule

// File: rtl/adc_seq_front.sv
module adc_seq_front
    import adc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic            ev_track,
    input  logic            ev_route,
    input  logic            ev_hold,
    input  logic [CH_W-1:0] chan,
    input  logic            single,
    input  logic            unipolar_in,
    output logic            track,
    output route_t          route,
    output logic            unipolar
);
    always_ff @(posedge clk) begin
        if (rst) begin
            track    <= 1'b0;
            route    <= '{pos: '0, neg: '0, neg_com: 1'b1};
            unipolar <= 1'b0;
        end else if (!active) begin
            track <= 1'b0;
        end else begin
            if (ev_track) begin
                track <= 1'b1;
            end else if (ev_hold) begin
                track <= 1'b0;
            end
            if (ev_route) begin
                route    <= decode_route(chan, single);
                unipolar <= unipolar_in;
            end
        end
    end
endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar
    import adc_seq_pkg::*;
#(
    parameter int WIDTH = RES_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             ev_hold,
    input  logic             ext_mode,
    input  logic             cmp,
    output logic [WIDTH-1:0] code,
    output logic             dout,
    output logic             strobe
);
    localparam int IDX_W = $clog2(WIDTH);
    localparam int OC_W  = $clog2(WIDTH + 1);
    localparam logic [WIDTH-1:0] MID = WIDTH'(1) << (WIDTH - 1);

    logic             busy;
    logic             deciding;
    logic [IDX_W-1:0] dec_idx;
    logic [OC_W-1:0]  out_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            deciding <= 1'b0;
            dec_idx  <= '0;
            out_cnt  <= '0;
            code     <= '0;
            dout     <= 1'b0;
            strobe   <= 1'b0;
        end else if (!active) begin
            busy     <= 1'b0;
            deciding <= 1'b0;
            dout     <= 1'b0;
            strobe   <= 1'b0;
        end else if (ev_hold) begin
            if (ext_mode) begin
                busy     <= 1'b1;
                deciding <= 1'b1;
                dec_idx  <= IDX_W'(WIDTH - 1);
                out_cnt  <= '0;
                code     <= MID;
                strobe   <= 1'b1;
            end else begin
                busy     <= 1'b0;
                deciding <= 1'b0;
                strobe   <= 1'b0;
            end
            dout <= 1'b0;
        end else begin
            if (sclk_rise && busy && deciding) begin
                for (int i = 0; i < WIDTH; i++) begin
                    if (i == int'(dec_idx)) begin
                        code[i] <= cmp;
                    end
                    if (i + 1 == int'(dec_idx)) begin
                        code[i] <= 1'b1;
                    end
                end
                if (dec_idx == '0) begin
                    deciding <= 1'b0;
                end else begin
                    dec_idx <= dec_idx - IDX_W'(1);
                end
            end
            if (sclk_fall && busy) begin
                strobe <= 1'b0;
                if (out_cnt == OC_W'(WIDTH)) begin
                    dout <= 1'b0;
                    busy <= 1'b0;
                end else begin
                    for (int i = 0; i < WIDTH; i++) begin
                        if (i == WIDTH - 1 - int'(out_cnt)) begin
                            dout <= code[i];
                        end
                    end
                    out_cnt <= out_cnt + OC_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic             cmp_in,
    output logic             dout,
    output logic             dout_oe,
    output logic             sstrb,
    output logic             sstrb_oe,
    output logic             th_track,
    output logic [CH_W-1:0]  mux_pos,
    output logic [CH_W-1:0]  mux_neg,
    output logic             neg_com,
    output logic             unipolar,
    output logic [RES_W-1:0] dac_code
);
    logic   active;
    logic   sclk_rise;
    logic   sclk_fall;
    logic   ev_track;
    logic   ev_route;
    logic   ev_hold;
    cmd_t   cmd;
    route_t route;
    logic   oe_q;

    adc_seq_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .active    (active),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    adc_seq_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din       (din),
        .ev_track  (ev_track),
        .ev_route  (ev_route),
        .ev_hold   (ev_hold),
        .cmd       (cmd)
    );

    adc_seq_front u_front (
        .clk         (clk),
        .rst         (rst),
        .active      (active),
        .ev_track    (ev_track),
        .ev_route    (ev_route),
        .ev_hold     (ev_hold),
        .chan        (cmd.chan),
        .single      (cmd.single),
        .unipolar_in (cmd.unipolar),
        .track       (th_track),
        .route       (route),
        .unipolar    (unipolar)
    );

    adc_seq_sar #(.WIDTH(RES_W)) u_sar (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .ev_hold   (ev_hold),
        .ext_mode  (cmd.mode == MODE_EXT_CLK),
        .cmp       (cmp_in),
        .code      (dac_code),
        .dout      (dout),
        .strobe    (sstrb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= active;
        end
    end

    assign dout_oe  = oe_q;
    assign sstrb_oe = oe_q;
    assign mux_pos  = route.pos;
    assign mux_neg  = route.neg;
    assign neg_com  = route.neg_com;
endmodule

// File: rtl/adc_serial_seq_chk.sv
module adc_serial_seq_chk
    import adc_seq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             sclk,
    input logic             dout,
    input logic             dout_oe,
    input logic             sstrb,
    input logic             th_track,
    input logic [CH_W-1:0]  mux_pos,
    input logic [CH_W-1:0]  mux_neg,
    input logic             neg_com,
    input logic [RES_W-1:0] dac_code
);
    logic       sclk_d;
    logic [1:0] strb_rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d     <= 1'b0;
            strb_rises <= '0;
        end else begin
            sclk_d <= sclk;
            if (!sstrb) begin
                strb_rises <= '0;
            end else if (sclk && !sclk_d && strb_rises != 2'd3) begin
                strb_rises <= strb_rises + 2'd1;
            end
        end
    end

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!dout_oe && !dout && !sstrb && !th_track)); // R9

    AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout) |-> ($past(cs_n) || (!$past(sclk) && $past(sclk, 2)))); // R7

    AST_STRB_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(sstrb) |-> ($past(cs_n) || (!$past(sclk) && $past(sclk, 2)))); // R5

    AST_STRB_ONE_PERIOD: assert property (@(posedge clk) disable iff (rst)
        strb_rises <= 2'd1); // R5

    AST_TRACK_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(th_track) |-> (!$past(sclk) && $past(sclk, 2))); // R3

    AST_SEARCH_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
        $rose(sstrb) |-> (dac_code == (RES_W'(1) << (RES_W - 1)))); // R6

    AST_DIFF_PAIR: assert property (@(posedge clk) disable iff (rst)
        !neg_com |-> (mux_pos[CH_W-1:1] == mux_neg[CH_W-1:1] && mux_pos[0] != mux_neg[0])); // R4
endmodule

bind adc_serial_seq adc_serial_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .dout     (dout),
    .dout_oe  (dout_oe),
    .sstrb    (sstrb),
    .th_track (th_track),
    .mux_pos  (mux_pos),
    .mux_neg  (mux_neg),
    .neg_com  (neg_com),
    .dac_code (dac_code)
);

// File: tb/test_adc_serial_seq.sv
module test_adc_serial_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic        cmp_in;
    logic        dout, dout_oe, sstrb, sstrb_oe, th_track, neg_com, unipolar;
    logic [2:0]  mux_pos, mux_neg;
    logic [11:0] dac_code;
    logic [11:0] vin = '0;

    int checks = 0;
    int failures = 0;
    int pushed = 0;
    int popped = 0;
    logic [11:0] exp_q[$];

    logic       lo_trk[1:40], lo_strb[1:40], hi_strb[1:40], lo_dout[1:40], lo_oe[1:40];
    logic       lo_com[1:40], lo_uni[1:40];
    logic [2:0] lo_pos[1:40], lo_neg[1:40];

    always #4 clk = ~clk;

    assign cmp_in = (dac_code <= vin);

    adc_serial_seq i_adc_serial_seq (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din), .cmp_in(cmp_in),
        .dout(dout), .dout_oe(dout_oe), .sstrb(sstrb), .sstrb_oe(sstrb_oe),
        .th_track(th_track), .mux_pos(mux_pos), .mux_neg(mux_neg), .neg_com(neg_com),
        .unipolar(unipolar), .dac_code(dac_code)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one sclk cycle: low half then high half; samples taken at the end of each half
    task automatic cyc(input logic b, input int k);
        sclk = 1'b0;
        din  = b;
        repeat (4) @(negedge clk);
        if (k > 0) begin
            lo_trk[k] = th_track; lo_strb[k] = sstrb; lo_dout[k] = dout; lo_oe[k] = dout_oe;
            lo_com[k] = neg_com; lo_uni[k] = unipolar; lo_pos[k] = mux_pos; lo_neg[k] = mux_neg;
        end
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        if (k > 0) hi_strb[k] = sstrb;
    endtask

    // driver: pushes the expected result, then sends the command
    task automatic run_frame(input logic [7:0] b, input int nz, input int after,
                             input bit push, input logic [11:0] v);
        vin = v;
        if (push) begin
            exp_q.push_back(v);
            pushed++;
        end
        if (cs_n) begin
            sclk = 1'b0;
            cs_n = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (nz) cyc(1'b0, 0);
        for (int k = 1; k <= 8 + after; k++) begin
            cyc((k <= 8) ? b[8-k] : 1'b0, k);
        end
    endtask

    task automatic end_frame();
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // monitor: collects 12 result bits after the strobe ends, compares with the queue
    logic        prev_s = 1'b0;
    logic        coll = 1'b0;
    int          nbit = 0;
    logic [11:0] acc = '0;
    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            coll   = 1'b0;
            prev_s = 1'b0;
        end else begin
            if (coll) begin
                acc = {acc[10:0], dout};
                nbit++;
                if (nbit == 12) begin
                    coll = 1'b0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R6/R7 unexpected result", int'(acc), 0);
                    end else begin
                        logic [11:0] e;
                        e = exp_q.pop_front();
                        popped++;
                        chk(acc == e, "R6/R7 result", int'(acc), int'(e));
                    end
                end
            end else if (prev_s && !sstrb) begin
                coll = 1'b1;
                acc  = {11'b0, dout};
                nbit = 1;
            end
            prev_s = sstrb;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        chk(!dout && !dout_oe && !sstrb && !sstrb_oe && !th_track && neg_com
            && mux_pos == 0 && !unipolar, "R9 reset state", int'(dout_oe), 0);

        // R1: clocks with select high are ignored
        for (int k = 1; k <= 10; k++) cyc(1'b1, k);
        begin
            bit quiet = 1'b1;
            for (int k = 1; k <= 10; k++)
                if (lo_trk[k] || lo_strb[k] || lo_oe[k] || hi_strb[k]) quiet = 1'b0;
            chk(quiet, "R1 no activity while deselected", int'(quiet), 1);
        end

        // R2, R4: differential channel 5 (0xDB), started cleanly after R1 stimulus
        run_frame(8'hDB, 0, 14, 1'b1, 12'h000);
        chk(lo_pos[7] == 3'd5 && lo_neg[7] == 3'd4 && !lo_com[7], "R4 diff ch5 route",
            int'(lo_neg[7]), 4);
        end_frame();

        // R4: differential channel 2, bipolar (0xA3)
        run_frame(8'hA3, 0, 14, 1'b1, 12'hFFF);
        chk(lo_pos[7] == 3'd2 && lo_neg[7] == 3'd3 && !lo_com[7] && !lo_uni[7],
            "R4 diff ch2 bipolar route", int'(lo_neg[7]), 3);
        end_frame();

        // R2, R3, R5, R7, R11: 0xFF after three leading zeros
        run_frame(8'hFF, 3, 14, 1'b1, 12'hA5C);
        chk(!lo_trk[5] && lo_trk[6], "R3 tracking opens after 5th bit", int'(lo_trk[6]), 1);
        chk(lo_trk[8] && !lo_trk[9], "R3 hold after 8th bit", int'(lo_trk[9]), 0);
        chk(!lo_strb[8] && lo_strb[9] && hi_strb[9] && !lo_strb[10],
            "R5 strobe one period", int'(lo_strb[10]), 0);
        chk(lo_pos[7] == 3'd7 && lo_com[7] && lo_uni[7], "R11 ch7 single unipolar",
            int'(lo_pos[7]), 7);
        chk(lo_dout[10] == 1'b1 && lo_dout[21] == 1'b0, "R7 MSB and LSB position",
            int'(lo_dout[10]), 1);
        chk(lo_dout[22] == 1'b0, "R7 dout low after LSB", int'(lo_dout[22]), 0);
        chk(lo_oe[2], "R9 outputs enabled while selected", int'(lo_oe[2]), 1);
        chk(lo_trk[1] == 1'b0, "R2 leading zeros ignored", int'(lo_trk[1]), 0);
        end_frame();

        // R10: internal-clock mode byte 0xBE, channel 3 single-ended
        run_frame(8'hBE, 0, 14, 1'b0, 12'hFFF);
        begin
            bit silent = 1'b1;
            for (int k = 1; k <= 22; k++) if (lo_strb[k] || lo_dout[k] || hi_strb[k]) silent = 1'b0;
            chk(silent, "R10 no conversion in other mode", int'(silent), 1);
        end
        chk(lo_trk[6] && lo_pos[7] == 3'd3 && lo_com[7], "R10 still tracks and routes",
            int'(lo_pos[7]), 3);
        end_frame();

        // R9: abort mid-conversion, then restart
        run_frame(8'hFF, 0, 4, 1'b0, 12'h555);
        end_frame();
        chk(!dout_oe && !sstrb_oe && !dout && !sstrb && !th_track, "R9 abort quiets outputs",
            int'(dout_oe), 0);
        run_frame(8'hFF, 0, 14, 1'b1, 12'h7FF);
        end_frame();
        run_frame(8'hFF, 0, 14, 1'b1, 12'h800);
        end_frame();

        // R8: back-to-back commands, 15 cycles apart
        run_frame(8'hFF, 0, 7, 1'b1, 12'h3C1);
        run_frame(8'hFF, 0, 14, 1'b1, 12'h3C1);
        chk(lo_strb[9] && !lo_strb[8], "R8 second strobe on cadence", int'(lo_strb[9]), 1);
        end_frame();

        repeat (10) @(negedge clk);
        chk(popped == pushed && exp_q.size() == 0, "R8 all results delivered", popped, pushed);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule